// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point condition holds. It takes a 6-bit predicate code and tests it against the condition-code bits held in a 32-bit floating-point status register. Conditional branch, conditional set and conditional trap instructions all use the same evaluator. The truth value and an illegal-code flag follow the predicate input combinationally. When the predicate is presented with a valid strobe, the status register is rewritten: its exception byte is cleared, and the unordered-compare exception is raised if the test needs it.

Predicates come in two halves. Codes 0 to 15 are the IEEE-aware tests. Codes 16 to 31 run the same comparisons, but they are not IEEE-aware, so an unordered operand counts as an exception. In each half, the upper eight codes are the logical complements of the lower eight. Codes 32 and above have no meaning and are flagged.

The arithmetic unit refreshes the condition codes through a load port. The load port writes the whole status word in one cycle.

Top module: `fpcc_eval_top`

## Requirements
- R1: After reset the status output is zero.
- R2: A predicate of 32 or above drives the illegal flag high and the truth output low. An evaluation strobe with such a predicate leaves the status word unchanged.
- R3: Condition codes sit in status bits 27 (N), 26 (Z), 25 (I) and 24 (NaN); bit 25 never affects a result. For codes 0 to 7 the truth output is:
  - 0: false
  - 1: Z
  - 2: no NaN, no Z and no N
  - 3: Z, or neither NaN nor N
  - 4: N with no NaN and no Z
  - 5: Z, or N without NaN
  - 6: neither NaN nor Z
  - 7: no NaN
- R4: For codes 8 to 15, the truth output is the complement of the result for code (c XOR 15).
- R5: For codes 16 to 31, the truth output equals the result for the code's low four bits.
- R6: A legal evaluation strobe writes the status back one cycle later. Bits 15:8 (the exception byte) are cleared, apart from bit 15 as R7 sets it, and all other bits are kept.
- R7: A strobe with a code from 16 to 31 while NaN is set writes bit 15 (unordered exception) as 1. Codes 0 to 15 never set it.
- R8: With no strobe and no load, the status word holds.
- R9: A load writes the load data into the status word on the next edge. A load takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_vld_i | input | 1 | Evaluation strobe: commit the status update |
| pred_i | input | 6 | Predicate code |
| ld_vld_i | input | 1 | Status load strobe |
| ld_data_i | input | 32 | Status load value |
| cond_true_o | output | 1 | Predicate result (combinational) |
| pred_bad_o | output | 1 | Predicate code is illegal (combinational) |
| status_o | output | 32 | Registered status word |

## Verification
The assertions check the following on every cycle:
- the illegal flag always forces the result low;
- the status word holds when idle or on an illegal strobe;
- a legal strobe clears the exception byte and keeps the other bits;
- the unordered bit is set only for non-aware tests with NaN set;
- a load takes priority.

The predicate truth table depends on a mapping from code to condition codes. Only the bench scenarios cover that mapping: they sweep every predicate against all sixteen condition-code combinations. That sweep is what shows the complement symmetry, the match between the two halves, and that bit 25 is ignored.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
    localparam int STAT_W  = 32;
    localparam int PRED_W  = 6;
    localparam int CC_LSB  = 24;
    localparam int EXC_LSB = 8;
    localparam int EXC_W   = 8;

    typedef struct packed {
        logic neg;
        logic zero;
        logic nan;
    } cc_t;

    typedef struct packed {
        logic       illegal;
        logic       nonaware;
        logic       invert;
        logic [2:0] base;
    } pred_fields_t;
endpackage

// File: rtl/fpcc_split.sv
module fpcc_split
    import fpcc_pkg::*;
#(
    parameter int PW = PRED_W
) (
    input  logic [PW-1:0] pred,
    output pred_fields_t  fields
);
    localparam int LOW_W = 5;

    always_comb begin
        fields          = '0;
        fields.illegal  = (pred >> LOW_W) != '0;
        fields.nonaware = pred[4];
        fields.invert   = pred[3];
        fields.base     = pred[2:0] ^ {3{pred[3]}};
    end
endmodule

// File: rtl/fpcc_base.sv
module fpcc_base
    import fpcc_pkg::*;
(
    input  cc_t        cc,
    input  logic [2:0] base,
    output logic       hit
);
    localparam int N_BASE = 8;

    logic [N_BASE-1:0] truth;

    always_comb begin
        truth[0] = 1'b0;
        truth[1] = cc.zero;
        truth[2] = !(cc.nan || cc.zero || cc.neg);
        truth[3] = cc.zero || !(cc.nan || cc.neg);
        truth[4] = cc.neg && !cc.nan && !cc.zero;
        truth[5] = cc.zero || (cc.neg && !cc.nan);
        truth[6] = !(cc.nan || cc.zero);
        truth[7] = !cc.nan;
        hit      = truth[base];
    end
endmodule

// File: rtl/fpcc_stat_next.sv
module fpcc_stat_next
    import fpcc_pkg::*;
#(
    parameter int SW   = STAT_W,
    parameter int ELSB = EXC_LSB,
    parameter int EW   = EXC_W
) (
    input  logic [SW-1:0] stat_cur,
    input  logic          nonaware,
    input  logic          nan,
    output logic [SW-1:0] stat_upd
);
    localparam int UNORD_BIT = ELSB + EW - 1;

    always_comb begin
        stat_upd               = stat_cur;
        stat_upd[ELSB +: EW]   = '0;
        if (nonaware && nan) begin
            stat_upd[UNORD_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/fpcc_eval_top.sv
module fpcc_eval_top
    import fpcc_pkg::*;
#(
    parameter int                SW        = STAT_W,
    parameter int                PW        = PRED_W,
    parameter int                CCL       = CC_LSB,
    parameter int                ELSB      = EXC_LSB,
    parameter int                EW        = EXC_W,
    parameter logic [STAT_W-1:0] RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval_vld_i,
    input  logic [PW-1:0] pred_i,
    input  logic          ld_vld_i,
    input  logic [SW-1:0] ld_data_i,
    output logic          cond_true_o,
    output logic          pred_bad_o,
    output logic [SW-1:0] status_o
);
    localparam int NAN_BIT  = CCL;
    localparam int ZERO_BIT = CCL + 2;
    localparam int NEG_BIT  = CCL + 3;

    typedef struct packed {
        logic [SW-1:0] status;
    } state_t;

    state_t       st_d, st_q;
    pred_fields_t fld;
    cc_t          cc;
    logic         base_hit;
    logic [SW-1:0] stat_upd;

    assign cc.neg  = st_q.status[NEG_BIT];
    assign cc.zero = st_q.status[ZERO_BIT];
    assign cc.nan  = st_q.status[NAN_BIT];

    fpcc_split #(.PW(PW)) u_split (
        .pred   (pred_i),
        .fields (fld)
    );

    fpcc_base u_base (
        .cc   (cc),
        .base (fld.base),
        .hit  (base_hit)
    );

    fpcc_stat_next #(.SW(SW), .ELSB(ELSB), .EW(EW)) u_next (
        .stat_cur (st_q.status),
        .nonaware (fld.nonaware),
        .nan      (cc.nan),
        .stat_upd (stat_upd)
    );

    always_comb begin
        st_d = st_q;
        if (ld_vld_i) begin
            st_d.status = ld_data_i;
        end else if (eval_vld_i && !fld.illegal) begin
            st_d.status = stat_upd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.status <= RESET_VAL[SW-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign cond_true_o = !fld.illegal && (base_hit ^ fld.invert);
    assign pred_bad_o  = fld.illegal;
    assign status_o    = st_q.status;
endmodule

// File: rtl/fpcc_eval_chk.sv
module fpcc_eval_chk #(
    parameter int SW = 32,
    parameter int PW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eval_vld_i,
    input logic [PW-1:0] pred_i,
    input logic          ld_vld_i,
    input logic [SW-1:0] ld_data_i,
    input logic          cond_true_o,
    input logic          pred_bad_o,
    input logic [SW-1:0] status_o
);
    logic legal_eval;
    assign legal_eval = eval_vld_i && !pred_bad_o && !ld_vld_i;

    AST_BAD_IS_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        pred_bad_o |-> !cond_true_o); // R2
    AST_BAD_HOLDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_vld_i && pred_bad_o && !ld_vld_i) |=> $stable(status_o)); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval_vld_i && !ld_vld_i) |=> $stable(status_o)); // R8
    AST_EXC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        legal_eval |=> status_o[14:8] == 7'd0); // R6
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        legal_eval |=> status_o[SW-1:16] == $past(status_o[SW-1:16])); // R6
    AST_LOWER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        legal_eval |=> status_o[7:0] == $past(status_o[7:0])); // R6
    AST_UNORD_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_eval && pred_i[4] && status_o[24]) |=> status_o[15]); // R7
    AST_AWARE_NO_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_eval && !pred_i[4]) |=> !status_o[15]); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_i |=> status_o == $past(ld_data_i)); // R9
endmodule

bind fpcc_eval_top fpcc_eval_chk #(.SW(SW), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval_vld_i  (eval_vld_i),
    .pred_i      (pred_i),
    .ld_vld_i    (ld_vld_i),
    .ld_data_i   (ld_data_i),
    .cond_true_o (cond_true_o),
    .pred_bad_o  (pred_bad_o),
    .status_o    (status_o)
);

// File: tb/tb_fpcc_eval_top.sv
module tb_fpcc_eval_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eval_vld_i = 1'b0;
    logic [5:0]  pred_i = '0;
    logic        ld_vld_i = 1'b0;
    logic [31:0] ld_data_i = '0;
    logic        cond_true_o;
    logic        pred_bad_o;
    logic [31:0] status_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpcc_eval_top dut (
        .clk(clk), .rst_n(rst_n), .eval_vld_i(eval_vld_i), .pred_i(pred_i),
        .ld_vld_i(ld_vld_i), .ld_data_i(ld_data_i), .cond_true_o(cond_true_o),
        .pred_bad_o(pred_bad_o), .status_o(status_o)
    );

    function automatic bit model(int p, bit n, bit z, bit nan);
        int c;
        bit inv, r;
        if (p >= 32) return 1'b0;
        c = p & 15;
        inv = (c >= 8);
        if (inv) c = c ^ 15;
        case (c)
            0: r = 1'b0;
            1: r = z;
            2: r = !(nan || z || n);
            3: r = z || !(nan || n);
            4: r = n && !nan && !z;
            5: r = z || (n && !nan);
            6: r = !(nan || z);
            default: r = !nan;
        endcase
        return r ^ inv;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_status(logic [31:0] v);
        @(negedge clk);
        ld_vld_i = 1'b1; ld_data_i = v;
        @(negedge clk);
        ld_vld_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset status", status_o, 32'h0);
    endtask

    task automatic sweep(int lo, int hi, string req);
        for (int cc = 0; cc < 16; cc++) begin
            load_status(32'(cc) << 24);
            for (int p = lo; p <= hi; p++) begin
                pred_i = 6'(p);
                #1;
                check(req, {31'd0, cond_true_o},
                      {31'd0, model(p, cc[3], cc[2], cc[0])});
            end
        end
    endtask

    task automatic t_illegal();
        load_status(32'h0F00_A5C3);
        for (int p = 32; p < 64; p += 7) begin
            @(negedge clk);
            pred_i = 6'(p); eval_vld_i = 1'b1;
            #1;
            check("R2 bad flag", {31'd0, pred_bad_o}, 32'd1);
            check("R2 truth low", {31'd0, cond_true_o}, 32'd0);
            @(negedge clk);
            eval_vld_i = 1'b0;
            check("R2 status kept", status_o, 32'h0F00_A5C3);
        end
        @(negedge clk);
        pred_i = 6'd63; #1;
        check("R2 bad flag 63", {31'd0, pred_bad_o}, 32'd1);
        pred_i = 6'd31; #1;
        check("R2 legal 31", {31'd0, pred_bad_o}, 32'd0);
    endtask

    task automatic eval_once(logic [5:0] p);
        @(negedge clk);
        pred_i = p; eval_vld_i = 1'b1;
        @(negedge clk);
        eval_vld_i = 1'b0;
    endtask

    task automatic t_writeback();
        load_status(32'h4C5A_FF3C);
        eval_once(6'd2);
        check("R6 exc cleared", status_o, 32'h4C5A_003C);
        load_status(32'h81A5_7E11);
        eval_once(6'd7);
        check("R7 aware no unord", status_o, 32'h81A5_0011);
        load_status(32'h81A5_7E11);
        eval_once(6'd23);
        check("R7 nonaware unord", status_o, 32'h81A5_8011);
        load_status(32'h8EA5_7E11);
        eval_once(6'd20);
        check("R7 nonaware no nan", status_o, 32'h8EA5_0011);
    endtask

    task automatic t_idle();
        load_status(32'h0DEF_FF99);
        repeat (5) @(negedge clk);
        check("R8 idle hold", status_o, 32'h0DEF_FF99);
    endtask

    task automatic t_priority();
        load_status(32'h0100_FF00);
        @(negedge clk);
        pred_i = 6'd17; eval_vld_i = 1'b1;
        ld_vld_i = 1'b1; ld_data_i = 32'h0200_1234;
        @(negedge clk);
        eval_vld_i = 1'b0; ld_vld_i = 1'b0;
        check("R9 load priority", status_o, 32'h0200_1234);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        sweep(0, 7, "R3 base code");
        sweep(8, 15, "R4 inverted code");
        sweep(16, 31, "R5 nonaware code");
        t_illegal();
        t_writeback();
        t_idle();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule